// File: doc/BRIEF.md
# DAC Register Readback I2C Slave

This block is the serial front end of a single-channel 12-bit DAC. It listens on a two-wire bus. It answers a 7-bit address whose upper five bits are fixed at 00110 and whose lower two bits come from two select pins. Writes arrive in groups of three bytes after the address byte: a command byte, then a data high byte, then a data low byte. The high nibble of the command picks which register the 16-bit data word updates. The block keeps the last command it executed.

A later read transfer does not use a register pointer. The block returns a 16-bit word chosen by the high nibble of the remembered command, high byte first, and then 0xFF for every further byte the master clocks. Readback is enabled only when the preceding completed write ended on a whole command group. The read may follow a STOP and START pair or a repeated START. Traffic to other addresses in between has no effect on it. SCL and SDA pass through two-flop synchronizers into the system clock domain. The only bus output is an SDA pull-down enable.

Top module: `dac_readback_i2c`

## Requirements
- R1: The block acknowledges an address byte whose first seven bits equal {00110, addrSel[1], addrSel[0]} by driving sdaPull high during the ninth clock. It does not acknowledge any other address. Bit 8 of the address byte is R/W, with 0 meaning write.
- R2: Every byte of an addressed write is acknowledged. Each third byte executes the group {command, high, low}, where value = word[15:4]. Nibble 0111 loads returnValue, 1000 loads codeValue, and 1001 loads both codeValue and dacValue. Nibbles 1010 and 1011 load dacValue. Nibble 0100 loads statusWord with the whole word, bit 12 forced to 1. Other nibbles change no register.
- R3: A read returns the selected word high byte first. Remembered nibble 0000 selects 0x5082, which is 01010, revision 000 and part 0x82.
- R4: Nibble 0111 reads {returnValue, 0000}, nibble 1000 reads {codeValue, 0000}, and nibbles 1001, 1010 and 1011 read {dacValue, 0000}.
- R5: Every other nibble reads statusWord. Its fields from the top are three flags, a constant 1, then twelve configuration bits.
- R6: Read bytes after the second one are 0xFF.
- R7: Readback is valid only when the last addressed write had a nonzero whole multiple of three bytes after the address. After a write that ends mid-group, every read byte is 0xFF, although the complete groups in that write still execute. A write with no bytes after the address changes nothing.
- R8: When a write holds several groups, the last executed command selects the readback.
- R9: Transfers to other addresses change no register and no readback state. The read may follow a STOP then START or a repeated START.
- R10: After the master NACKs a read byte, SDA stays released until the next START.
- R11: After reset, SDA is released, the value registers are 0, statusWord is 0x1000, and reads return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| addrSel | input | 2 | Low two bits of the slave address |
| sdaPull | output | 1 | High pulls SDA low |
| dacValue | output | 12 | DAC register |
| codeValue | output | 12 | Code register |
| returnValue | output | 12 | Return register |
| statusWord | output | 16 | Packed flags and configuration word |

## Verification
The bench targets writes that stop after one, two or four bytes. A design that counted bytes wrongly would enable readback on a partial group, or would drop the group that did complete. It writes several groups in one transfer, which catches a design that reads back the first command instead of the last. It sends a master NACK after the first read byte; a design that ignored it would then drive the low byte onto the bus. It also sends foreign-address writes and uses repeated STARTs, which expose a decoder that latches other traffic or loses its state when no STOP arrives.

// File: rtl/rb_pkg.sv
package rb_pkg;
  // one-cycle strobes from the bus control to the register datapath
  typedef struct packed {
    logic       byteValid;   // a write byte was received
    logic [1:0] bytePos;     // 0 command, 1 data high, 2 data low
    logic [7:0] byteVal;
    logic       writeDone;   // an addressed write transfer ended
    logic       writeWhole;  // it ended on a whole command group
  } rbStrobe_t;
endpackage

// File: rtl/rb_bus_ctrl.sv
module rb_bus_ctrl
  import rb_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b00110,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [1:0]  addrSel,
  input  logic [15:0] readWord,
  output rbStrobe_t   strobe,
  output logic        sdaPull
);
  typedef enum logic [3:0] {
    IDLE, ADDR, ADDR_ACK, WR_BYTE, WR_ACK, RD_BYTE, RD_ACKCHK, RD_NEXT, IGNORE
  } busState_t;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startSeen, stopSeen;
  busState_t state;
  logic [3:0] bitCnt;
  logic [7:0] rxByte;
  logic [6:0] txRest;
  logic [1:0] txIdx, groupIdx;
  logic isRead, anyByte;
  logic [7:0] nextByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS      = sclSync[SYNC_STAGES-1];
  assign sdaS      = sdaSync[SYNC_STAGES-1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign nextByte  = (txIdx == 2'd1) ? readWord[7:0] : 8'hFF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE;
      bitCnt <= '0;
      rxByte <= '0;
      txRest <= '1;
      txIdx <= '0;
      groupIdx <= '0;
      isRead <= 1'b0;
      anyByte <= 1'b0;
      sdaPull <= 1'b0;
      strobe <= '0;
    end else begin
      strobe <= '0;
      if (startSeen || stopSeen) begin
        if ((state == WR_BYTE || state == WR_ACK) && anyByte) begin
          strobe.writeDone  <= 1'b1;
          strobe.writeWhole <= (groupIdx == 2'd0);
        end
        state   <= startSeen ? ADDR : IDLE;
        bitCnt  <= '0;
        sdaPull <= 1'b0;
      end else if (sclRise) begin
        case (state)
          ADDR, WR_BYTE: begin
            rxByte <= {rxByte[6:0], sdaS};
            bitCnt <= bitCnt + 4'd1;
          end
          RD_BYTE:   bitCnt <= bitCnt + 4'd1;
          RD_ACKCHK: state <= sdaS ? IGNORE : RD_NEXT;
          default: ;
        endcase
      end else if (sclFall) begin
        case (state)
          ADDR: if (bitCnt == 4'd8) begin
            bitCnt <= '0;
            if (rxByte[7:1] == {ADDR_PREFIX, addrSel}) begin
              sdaPull  <= 1'b1;
              isRead   <= rxByte[0];
              anyByte  <= 1'b0;
              groupIdx <= '0;
              state    <= ADDR_ACK;
            end else begin
              state <= IGNORE;
            end
          end
          ADDR_ACK: if (isRead) begin
            txRest  <= readWord[14:8];
            sdaPull <= ~readWord[15];
            txIdx   <= 2'd1;
            state   <= RD_BYTE;
          end else begin
            sdaPull <= 1'b0;
            state   <= WR_BYTE;
          end
          WR_BYTE: if (bitCnt == 4'd8) begin
            strobe.byteValid <= 1'b1;
            strobe.bytePos   <= groupIdx;
            strobe.byteVal   <= rxByte;
            groupIdx <= (groupIdx == 2'd2) ? 2'd0 : groupIdx + 2'd1;
            anyByte  <= 1'b1;
            sdaPull  <= 1'b1;
            bitCnt   <= '0;
            state    <= WR_ACK;
          end
          WR_ACK: begin
            sdaPull <= 1'b0;
            state   <= WR_BYTE;
          end
          RD_BYTE: if (bitCnt == 4'd8) begin
            sdaPull <= 1'b0;
            bitCnt  <= '0;
            state   <= RD_ACKCHK;
          end else begin
            sdaPull <= ~txRest[6];
            txRest  <= {txRest[5:0], 1'b1};
          end
          RD_NEXT: begin
            txRest  <= nextByte[6:0];
            sdaPull <= ~nextByte[7];
            txIdx   <= 2'd2;
            state   <= RD_BYTE;
          end
          default: ;
        endcase
      end
    end
  end

  AST_SDA_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPull != $past(sdaPull)) |-> !sclS); // R1
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.byteValid, strobe.writeDone})); // R2
  AST_NACK_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (state == RD_ACKCHK && sclRise && sdaS) |=> (!sdaPull && state == IGNORE)); // R10
endmodule

// File: rtl/rb_reg_path.sv
module rb_reg_path
  import rb_pkg::*;
#(
  parameter int DATA_BITS = 12,
  parameter logic [7:0] PART_ID = 8'h82,
  parameter logic [2:0] REV_ID = 3'b000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rbStrobe_t            strobe,
  output logic [15:0]          readWord,
  output logic [DATA_BITS-1:0] dacValue,
  output logic [DATA_BITS-1:0] codeValue,
  output logic [DATA_BITS-1:0] returnValue,
  output logic [15:0]          statusWord
);
  localparam int PAD = 16 - DATA_BITS;

  logic [3:0] pendNib, lastNib;
  logic [7:0] pendHi;
  logic [15:0] execWord;
  logic [DATA_BITS-1:0] execVal, retReg, codeReg, dacReg;
  logic [15:0] cfgReg, retJust, codeJust, dacJust;
  logic rbValid;

  assign execWord = {pendHi, strobe.byteVal};
  assign execVal  = execWord[15 -: DATA_BITS];

  generate
    if (PAD > 0) begin : g_pad
      assign retJust  = {retReg,  {PAD{1'b0}}};
      assign codeJust = {codeReg, {PAD{1'b0}}};
      assign dacJust  = {dacReg,  {PAD{1'b0}}};
    end else begin : g_full
      assign retJust  = retReg;
      assign codeJust = codeReg;
      assign dacJust  = dacReg;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendNib <= '0;
      pendHi  <= '0;
      lastNib <= '0;
      retReg  <= '0;
      codeReg <= '0;
      dacReg  <= '0;
      cfgReg  <= 16'h1000;
      rbValid <= 1'b0;
    end else begin
      if (strobe.writeDone) rbValid <= strobe.writeWhole;
      if (strobe.byteValid) begin
        case (strobe.bytePos)
          2'd0: pendNib <= strobe.byteVal[7:4];
          2'd1: pendHi  <= strobe.byteVal;
          default: begin
            lastNib <= pendNib;
            case (pendNib)
              4'b0111: retReg <= execVal;
              4'b1000: codeReg <= execVal;
              4'b1001: begin codeReg <= execVal; dacReg <= execVal; end
              4'b1010, 4'b1011: dacReg <= execVal;
              4'b0100: cfgReg <= execWord | 16'h1000;
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  always_comb begin
    if (!rbValid) readWord = 16'hFFFF;
    else begin
      case (lastNib)
        4'b0000: readWord = {5'b01010, REV_ID, PART_ID};
        4'b0111: readWord = retJust;
        4'b1000: readWord = codeJust;
        4'b1001, 4'b1010, 4'b1011: readWord = dacJust;
        default: readWord = cfgReg;
      endcase
    end
  end

  assign dacValue    = dacReg;
  assign codeValue   = codeReg;
  assign returnValue = retReg;
  assign statusWord  = cfgReg;

  AST_DAC_ONLY_ON_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    (dacReg != $past(dacReg)) |-> $past(strobe.byteValid && strobe.bytePos == 2'd2)); // R2
  AST_VALID_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    (rbValid != $past(rbValid)) |-> $past(strobe.writeDone)); // R7
  AST_STATUS_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[12]); // R5
endmodule

// File: rtl/dac_readback_i2c.sv
module dac_readback_i2c
  import rb_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b00110,
  parameter int DATA_BITS = 12,
  parameter logic [7:0] PART_ID = 8'h82,
  parameter logic [2:0] REV_ID = 3'b000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic [1:0]           addrSel,
  output logic                 sdaPull,
  output logic [DATA_BITS-1:0] dacValue,
  output logic [DATA_BITS-1:0] codeValue,
  output logic [DATA_BITS-1:0] returnValue,
  output logic [15:0]          statusWord
);
  rbStrobe_t strobe;
  logic [15:0] readWord;

  rb_bus_ctrl #(.ADDR_PREFIX(ADDR_PREFIX), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .readWord(readWord), .strobe(strobe), .sdaPull(sdaPull));

  rb_reg_path #(.DATA_BITS(DATA_BITS), .PART_ID(PART_ID), .REV_ID(REV_ID)) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .readWord(readWord),
    .dacValue(dacValue), .codeValue(codeValue), .returnValue(returnValue),
    .statusWord(statusWord));
endmodule

// File: tb/test_dac_readback_i2c.sv
module test_dac_readback_i2c;
  localparam int Q = 5;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic [1:0] addrSel = 2'b10;
  logic sdaPull, sdaLine;
  logic [11:0] dacValue, codeValue, returnValue;
  logic [15:0] statusWord;
  assign sdaLine = sdaDrv & ~sdaPull;

  dac_readback_i2c i_dac_readback_i2c (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaPull(sdaPull), .dacValue(dacValue), .codeValue(codeValue),
    .returnValue(returnValue), .statusWord(statusWord));

  int total = 0, bad = 0;
  logic [11:0] mRet = 0, mCode = 0, mDac = 0;
  logic [15:0] mCfg = 16'h1000;
  logic [3:0] mLast = 0, mPend = 0;
  logic [7:0] mHi = 0;
  bit mValid = 0;
  logic [7:0] wbuf [0:7];
  logic [6:0] myAddr;
  assign myAddr = {5'b00110, addrSel};

  function automatic logic [15:0] expWord();
    if (!mValid) return 16'hFFFF;
    case (mLast)
      4'b0000: return 16'h5082;
      4'b0111: return {mRet, 4'h0};
      4'b1000: return {mCode, 4'h0};
      4'b1001, 4'b1010, 4'b1011: return {mDac, 4'h0};
      default: return mCfg;
    endcase
  endfunction

  task automatic modelByte(int pos, logic [7:0] b);
    logic [15:0] w;
    if (pos == 0) mPend = b[7:4];
    else if (pos == 1) mHi = b;
    else begin
      w = {mHi, b};
      mLast = mPend;
      case (mPend)
        4'b0111: mRet = w[15:4];
        4'b1000: mCode = w[15:4];
        4'b1001: begin mCode = w[15:4]; mDac = w[15:4]; end
        4'b1010, 4'b1011: mDac = w[15:4];
        4'b0100: mCfg = w | 16'h1000;
        default: ;
      endcase
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkRegs(string req);
    check(req, {4'h0, dacValue}, {4'h0, mDac});
    check(req, {4'h0, codeValue}, {4'h0, mCode});
    check(req, {4'h0, returnValue}, {4'h0, mRet});
    check(req, statusWord, mCfg);
  endtask

  task automatic i2cStart();
    sdaDrv = 1; tick(Q); sclDrv = 1; tick(Q); sdaDrv = 0; tick(Q); sclDrv = 0; tick(Q);
  endtask
  task automatic i2cStop();
    sdaDrv = 0; tick(Q); sclDrv = 1; tick(Q); sdaDrv = 1; tick(Q);
  endtask
  task automatic sendBit(logic b);
    sdaDrv = b; tick(Q); sclDrv = 1; tick(2*Q); sclDrv = 0; tick(Q);
  endtask
  task automatic getBit(output logic b);
    sdaDrv = 1; tick(Q); sclDrv = 1; tick(Q); b = sdaLine; tick(Q); sclDrv = 0; tick(Q);
  endtask
  task automatic sendByte(logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    getBit(a);
    ack = !a;
  endtask
  task automatic getByte(logic masterAck, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) getBit(d[i]);
    sendBit(!masterAck);
  endtask

  // R1 R2 R9: write n bytes from wbuf to address addr
  task automatic doWrite(logic [6:0] addr, int n, bit sendStop);
    logic ack;
    bit match;
    match = (addr == myAddr);
    i2cStart();
    sendByte({addr, 1'b0}, ack);
    check(match ? "R1 address ack" : "R1 foreign address no ack", {15'h0, ack}, {15'h0, match});
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], ack);
      check(match ? "R2 write byte ack" : "R9 foreign byte no ack", {15'h0, ack}, {15'h0, match});
      if (match) modelByte(i % 3, wbuf[i]);
    end
    if (match && n > 0) mValid = (n % 3 == 0);
    if (sendStop) i2cStop();
    tick(4);
  endtask

  task automatic doRead(string req, int nBytes);
    logic ack;
    logic [7:0] d;
    logic [15:0] w;
    w = expWord();
    i2cStart();
    sendByte({myAddr, 1'b1}, ack);
    check({req, " read address ack"}, {15'h0, ack}, 16'h1);
    for (int i = 0; i < nBytes; i++) begin
      getByte(i < nBytes - 1, d);
      check(req, {8'h0, d}, {8'h0, (i == 0) ? w[15:8] : (i == 1) ? w[7:0] : 8'hFF});
    end
    i2cStop();
    tick(4);
  endtask

  task automatic grp(int base, logic [7:0] c, logic [15:0] v);
    wbuf[base] = c; wbuf[base+1] = v[15:8]; wbuf[base+2] = v[7:0];
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    int n;
    void'($urandom(32'd2024));
    tick(5);
    rstN = 1;
    tick(5);
    check("R11 reset sda released", {15'h0, sdaPull}, 16'h0);
    checkRegs("R11 reset registers");
    doRead("R11 reset read ones", 2);

    grp(0, 8'h00, 16'h0000); doWrite(myAddr, 3, 1); doRead("R3 identity word", 2);
    grp(0, 8'h71, 16'hABCD); doWrite(myAddr, 3, 1);
    checkRegs("R2 return write"); doRead("R4 return readback", 2);
    grp(0, 8'h85, 16'h1234); doWrite(myAddr, 3, 1);
    checkRegs("R2 code write"); doRead("R4 code readback", 2);
    grp(0, 8'h93, 16'h5678); doWrite(myAddr, 3, 1);
    checkRegs("R2 code and dac write"); doRead("R4 dac readback 1001", 2);
    grp(0, 8'hA0, 16'h9ABF); doWrite(myAddr, 3, 1);
    checkRegs("R2 dac write"); doRead("R4 dac readback 1010", 2);
    grp(0, 8'h4C, 16'hE5A5); doWrite(myAddr, 3, 1);
    checkRegs("R2 status write"); doRead("R5 status readback", 2);
    grp(0, 8'hF3, 16'h0000); doWrite(myAddr, 3, 1); doRead("R5 other nibble status", 2);
    doRead("R6 extra bytes ones", 5);

    grp(0, 8'h00, 16'h0000); doWrite(myAddr, 2, 1); doRead("R7 two byte write", 2);
    grp(0, 8'h00, 16'h0000); doWrite(myAddr, 3, 1); doRead("R7 whole group reenables", 2);
    grp(0, 8'h71, 16'h1110); wbuf[3] = 8'h85; doWrite(myAddr, 4, 1);
    checkRegs("R7 four byte write executes group"); doRead("R7 four byte write", 2);
    grp(0, 8'h85, 16'h2220); doWrite(myAddr, 1, 1); doRead("R7 one byte write", 2);
    doWrite(myAddr, 0, 1); doRead("R7 empty write keeps state", 2);
    grp(0, 8'h85, 16'h2220); grp(3, 8'h00, 16'h0000); doWrite(myAddr, 6, 1);
    checkRegs("R8 multi group"); doRead("R8 last command", 2);

    grp(0, 8'h93, 16'hFFFF); doWrite({5'b00110, ~addrSel}, 3, 1);
    checkRegs("R9 foreign write ignored"); doRead("R9 readback after foreign", 2);
    grp(0, 8'h71, 16'h7770); doWrite(myAddr, 3, 0); doRead("R9 repeated start read", 2);

    grp(0, 8'h00, 16'h0000); doWrite(myAddr, 3, 1);
    i2cStart();
    sendByte({myAddr, 1'b1}, ack);
    getByte(1'b0, d);
    check("R10 first byte before nack", {8'h0, d}, 16'h0050);
    getByte(1'b0, d);
    check("R10 released after nack", {8'h0, d}, 16'h00FF);
    i2cStop();
    tick(4);

    for (int it = 0; it < 30; it++) begin
      n = ($urandom % 4 == 0) ? (1 + $urandom % 6) : 3;
      for (int i = 0; i < 8; i++) wbuf[i] = 8'($urandom);
      if ($urandom % 5 == 0) doWrite({5'b00110, addrSel ^ 2'b01}, n, 1);
      else doWrite(myAddr, n, ($urandom % 2) == 1);
      checkRegs("R2 random registers");
      doRead("R3 random readback", 2 + $urandom % 2);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule